// File: doc/BRIEF.md
# Serial Word Receiver

This block takes a bit-serial data stream and assembles it into parallel words for a processor to read. A bit clock samples the data line. Each word passes through three stages: a shift register, a holding buffer and a data register the processor reads. The bit clock is either an external clock input or an internal clock made by dividing the system clock. Its sampling edge can be rising or falling. A frame sync input marks the first bit of each word.

All inputs are brought into the system clock domain, and the selected clock edge is detected there. A small state machine in the shifter has two states. In `SH_IDLE` it waits for a frame. In `SH_SHIFT` it collects bits. The transition *start* (SH_IDLE→SH_SHIFT) fires on an active edge with frame sync high, and that edge captures the first bit. The transition *finish* (SH_SHIFT→SH_IDLE) fires on the edge that captures the last bit. If frame sync is still high, the next edge starts a new word, so words can run back to back. The processor watches a ready flag and pulses a read strobe to consume each word.

Top module: `serial_rx_path`

## Requirements
- R1: Exactly one data bit is captured per active bit-clock edge while a word is assembled, and the first bit received becomes the most significant bit of the word.
- R2: `cfg_edge_rise` = 1 selects the rising edge of the bit clock as the sampling edge; 0 selects the falling edge.
- R3: `cfg_clk_int` = 1 takes the bit clock from the internal divider; 0 takes it from `ext_clk`.
- R4: The internal bit clock toggles every `cfg_div`+1 system cycles, so one bit lasts 2·(`cfg_div`+1) system cycles and back-to-back 8-bit words complete every 16·(`cfg_div`+1) cycles.
- R5: `cfg_len` codes 0,1,2,3,4,5 select word lengths of 8,12,16,20,24,32 bits; codes 6 and 7 select 32.
- R6: A word enters the buffer only after its last bit is captured, and it moves on to the data register when that register is empty; in `rd_data` it is right-justified with the upper bits zero.
- R7: While idle, an active edge with `fsync` high starts a word and captures its first bit; active edges with `fsync` low produce no word.
- R8: After reset `rd_ready`, `overrun` and `rd_data` are 0. `rd_ready` rises when a word lands in the data register, holds with `rd_data` stable until `rd_en`, and falls in the cycle after `rd_en`.
- R9: A word that completes while the buffer is full and the data register is unread is discarded and sets `overrun`, which stays set until `rd_en`; the buffered and unread words are still delivered in order.
- R10: Active bit-clock edges are never detected on two consecutive system cycles, which keeps the bit rate at or below half the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk_int | input | 1 | 1: internal bit clock, 0: external |
| cfg_edge_rise | input | 1 | 1: sample on rising edge, 0: falling |
| cfg_div | input | 8 | Internal divider half-period minus one |
| cfg_len | input | 3 | Word length code |
| ext_clk | input | 1 | External bit clock |
| ser_din | input | 1 | Serial data |
| fsync | input | 1 | Frame sync, high with the first bit |
| rd_en | input | 1 | Read strobe, consumes the data register |
| rd_data | output | 32 | Data register contents |
| rd_ready | output | 1 | Data register holds an unread word |
| overrun | output | 1 | A word was lost |

## Verification
The hardest state to reach is the overrun: the buffer and the data register must both be full when a third word finishes. The stimulus sends three framed words back to back without reading. It then checks that the first word is presented and the flag is raised. It reads twice to see the second word appear and the third word absent. The internal clock is not visible at the ports, so its timing is checked through the spacing of successive ready rises while frame sync is held high.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic {SH_IDLE, SH_SHIFT} srx_state_e;

    // Map the length code to a bit count.
    function automatic logic [5:0] len_bits(input logic [2:0] code);
        unique case (code)
            3'd0:    len_bits = 6'd8;
            3'd1:    len_bits = 6'd12;
            3'd2:    len_bits = 6'd16;
            3'd3:    len_bits = 6'd20;
            3'd4:    len_bits = 6'd24;
            default: len_bits = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_int,
    input  logic             edge_rise,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_clk,
    input  logic             din,
    input  logic             fsync,
    output logic             tick,
    output logic             din_s,
    output logic             fsync_s
);
    logic [2:0]       sync_q;
    logic [DIV_W-1:0] cnt_q;
    logic             int_clk_q;
    logic             prev_q;
    logic             sel_clk;

    srx_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ext_clk, din, fsync}),
        .q    (sync_q)
    );

    assign din_s   = sync_q[1];
    assign fsync_s = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            int_clk_q <= 1'b0;
        end else if (cnt_q >= div) begin
            cnt_q     <= '0;
            int_clk_q <= ~int_clk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sel_clk = use_int ? int_clk_q : sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_clk;
    end

    assign tick = edge_rise ? (sel_clk & ~prev_q) : (~sel_clk & prev_q);
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
    import srx_pkg::*;
#(
    parameter int MAX_W = 32,
    localparam int CW   = $clog2(MAX_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             din,
    input  logic             fsync,
    input  logic [2:0]       len_code,
    output logic             word_done,
    output logic [MAX_W-1:0] word
);
    srx_state_e       state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [MAX_W-1:0] sreg_q;
    logic [CW-1:0]    last_idx;

    assign last_idx = CW'(len_bits(len_code) - 6'd1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:  if (tick && fsync)               state_d = SH_SHIFT; // start
            SH_SHIFT: if (tick && cnt_q == last_idx)   state_d = SH_IDLE;  // finish
            default:                                   state_d = SH_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sreg_q    <= '0;
            word_done <= 1'b0;
            word      <= '0;
        end else begin
            word_done <= 1'b0;
            unique case (state_q)
                SH_IDLE: begin
                    if (tick && fsync) begin
                        sreg_q <= {{(MAX_W-1){1'b0}}, din};
                        cnt_q  <= CW'(1);
                    end
                end
                SH_SHIFT: begin
                    if (tick) begin
                        sreg_q <= {sreg_q[MAX_W-2:0], din};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == last_idx) begin
                            word_done <= 1'b1;
                            word      <= {sreg_q[MAX_W-2:0], din};
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx_path.sv
module serial_rx_path #(
    parameter int DIV_W = 8,
    parameter int MAX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_clk_int,
    input  logic             cfg_edge_rise,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [2:0]       cfg_len,
    input  logic             ext_clk,
    input  logic             ser_din,
    input  logic             fsync,
    input  logic             rd_en,
    output logic [MAX_W-1:0] rd_data,
    output logic             rd_ready,
    output logic             overrun
);
    logic             bit_tick, din_s, fsync_s;
    logic             word_done;
    logic [MAX_W-1:0] word;
    logic [MAX_W-1:0] rbr_q;
    logic             rbr_full;
    logic             move, accept, lost;

    srx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_int  (cfg_clk_int),
        .edge_rise(cfg_edge_rise),
        .div      (cfg_div),
        .ext_clk  (ext_clk),
        .din      (ser_din),
        .fsync    (fsync),
        .tick     (bit_tick),
        .din_s    (din_s),
        .fsync_s  (fsync_s)
    );

    srx_shifter #(.MAX_W(MAX_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .din      (din_s),
        .fsync    (fsync_s),
        .len_code (cfg_len),
        .word_done(word_done),
        .word     (word)
    );

    assign move   = rbr_full && !rd_ready;
    assign accept = word_done && (!rbr_full || move);
    assign lost   = word_done && rbr_full && !move;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbr_q    <= '0;
            rbr_full <= 1'b0;
            rd_data  <= '0;
            rd_ready <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (accept) begin
                rbr_q    <= word;
                rbr_full <= 1'b1;
            end else if (move) begin
                rbr_full <= 1'b0;
            end
            if (move) begin
                rd_data  <= rbr_q;
                rd_ready <= 1'b1;
            end else if (rd_en) begin
                rd_ready <= 1'b0;
            end
            if (lost)       overrun <= 1'b1;
            else if (rd_en) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int MAX_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             rd_ready,
    input logic [MAX_W-1:0] rd_data,
    input logic             overrun,
    input logic             bit_tick,
    input logic             word_done,
    input logic             rbr_full
);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_ready |=> !rd_ready);

    a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready && !rd_en |=> rd_ready && $stable(rd_data));

    a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !rd_en |=> overrun);

    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(word_done && rbr_full && rd_ready));

    a_r6_fill_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rbr_full) |-> $past(word_done));
endmodule

bind serial_rx_path srx_checker #(.MAX_W(MAX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .overrun  (overrun),
    .bit_tick (bit_tick),
    .word_done(word_done),
    .rbr_full (rbr_full)
);

// File: tb/serial_rx_path_bench.sv
module serial_rx_path_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_clk_int = 1'b0, cfg_edge_rise = 1'b1;
    logic [7:0]  cfg_div = 8'd0;
    logic [2:0]  cfg_len = 3'd0;
    logic        ext_clk = 1'b0, ser_din = 1'b0, fsync = 1'b0, rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_ready, overrun;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    serial_rx_path u_serial_rx_path (
        .clk(clk), .rst_n(rst_n), .cfg_clk_int(cfg_clk_int),
        .cfg_edge_rise(cfg_edge_rise), .cfg_div(cfg_div), .cfg_len(cfg_len),
        .ext_clk(ext_clk), .ser_din(ser_din), .fsync(fsync), .rd_en(rd_en),
        .rd_data(rd_data), .rd_ready(rd_ready), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sysw(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send one framed word on the external clock, MSB first.
    task automatic send_word(input logic [31:0] val, input int nbits, input bit framed);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk);
            ext_clk = ~cfg_edge_rise;
            ser_din = val[i];
            fsync   = framed && (i == nbits - 1);
            sysw(HALF_BIT);
            ext_clk = cfg_edge_rise;
            sysw(HALF_BIT);
        end
        fsync = 1'b0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 200; k++) begin
            if (rd_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic read_word();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R8 reset ready", {31'b0, rd_ready}, 32'd0);
        check("R8 reset overrun", {31'b0, overrun}, 32'd0);
        check("R8 reset data", rd_data, 32'd0);
    endtask

    task automatic t_rise8();
        cfg_edge_rise = 1'b1; cfg_len = 3'd0;
        send_word(32'hA5, 8, 1'b1);
        wait_ready();
        check("R1 R2 R7 rising 8-bit msb first", rd_data, 32'h0000_00A5);
        check("R8 ready set", {31'b0, rd_ready}, 32'd1);
        sysw(5);
        check("R8 data held unread", rd_data, 32'h0000_00A5);
        read_word();
        check("R8 ready cleared by read", {31'b0, rd_ready}, 32'd0);
    endtask

    task automatic t_fall16();
        cfg_edge_rise = 1'b0; cfg_len = 3'd2;
        send_word(32'h1234, 16, 1'b1);
        wait_ready();
        check("R2 falling edge 16-bit", rd_data, 32'h0000_1234);
        read_word();
        cfg_edge_rise = 1'b1;
        sysw(4);
    endtask

    task automatic t_lengths();
        logic [31:0] v [6] = '{32'hABC, 32'hF0F0F, 32'hC3A55A, 32'hDEADBEEF, 32'h8001, 32'h9E};
        int          n [6] = '{12, 20, 24, 32, 32, 8};
        logic [2:0]  c [6] = '{3'd1, 3'd3, 3'd4, 3'd5, 3'd7, 3'd0};
        for (int j = 0; j < 6; j++) begin
            cfg_len = c[j];
            send_word(v[j], n[j], 1'b1);
            wait_ready();
            check("R5 R6 length code and right-justify", rd_data, v[j]);
            read_word();
        end
    endtask

    task automatic t_unframed();
        cfg_len = 3'd0;
        send_word(32'hFF, 8, 1'b0);
        sysw(30);
        check("R7 no word without frame sync", {31'b0, rd_ready}, 32'd0);
        send_word(32'h3C, 8, 1'b1);
        wait_ready();
        check("R7 framed word after idle edges", rd_data, 32'h3C);
        read_word();
    endtask

    task automatic t_overrun();
        cfg_len = 3'd0;
        send_word(32'h11, 8, 1'b1);
        send_word(32'h22, 8, 1'b1);
        send_word(32'h33, 8, 1'b1);
        sysw(20);
        check("R9 overrun set", {31'b0, overrun}, 32'd1);
        check("R9 first word kept", rd_data, 32'h11);
        read_word();
        wait_ready();
        check("R9 overrun cleared by read", {31'b0, overrun}, 32'd0);
        check("R9 buffered word delivered", rd_data, 32'h22);
        read_word();
        sysw(20);
        check("R9 third word discarded", {31'b0, rd_ready}, 32'd0);
    endtask

    task automatic t_internal();
        int t1, t2;
        cfg_len = 3'd0; cfg_div = 8'd2; cfg_edge_rise = 1'b1;
        ser_din = 1'b1; fsync = 1'b1;
        cfg_clk_int = 1'b1;
        wait_ready(); read_word();
        wait_ready(); t1 = cyc;
        check("R3 internal clock word", rd_data, 32'hFF);
        read_word();
        wait_ready(); t2 = cyc;
        check("R4 R10 word spacing", t2 - t1, 32'd48);
        read_word();
        fsync = 1'b0; cfg_clk_int = 1'b0; ser_din = 1'b0;
        sysw(60);
        if (rd_ready) read_word();
    endtask

    initial begin
        sysw(3);
        rst_n = 1'b1;
        sysw(2);
        t_reset();
        t_rise8();
        t_fall16();
        t_lengths();
        t_unframed();
        t_overrun();
        t_internal();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule